// File: doc/BRIEF.md
# Coprocessor Error Interrupt Event Controller

This unit sits beside a math coprocessor and turns its condition pulses into something software can read and react to. Five error sources each set a sticky flag: floating-point overflow, floating-point NaN, fixed-point overflow, subnormal truncation (underflow) and a bus error from the coprocessor's memory master. A sixth source, the instruction-completion pulse, sets no flag but can still notify.

Two enable masks, each with the same bit layout, decide separately how each source is reported. The interrupt mask feeds a single summary status bit. This bit latches and drives a level interrupt until software writes to the status register. The event mask drives a one-cycle trigger output that never latches. Software reaches the four registers over a simple single-cycle read/write bus. Reads are combinational and writes take effect at the clock edge.

Top module: `cpx_notify_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads 0 and both `irq_o` and `evt_o` are low.
- R2: A pulse on `err_pulse[i]` sets error flag i. The flags read back at offset 0x0 with overflow at bit 0, NaN at bit 1, fixed-point overflow at bit 2, underflow at bit 3 and bus error at bit 4. A flag remains set until software clears it.
- R3: A write to offset 0x0 clears each flag whose written bit is 1. Flags at written 0 bits are not changed.
- R4: If an error pulse and a clearing write to offset 0x0 hit the same flag in the same cycle, the flag ends up set.
- R5: The interrupt mask (offset 0x4) and the event mask (offset 0x8) store only bits 0-4 (error sources, same order as R2) and bit 7 (completion). All other bits read 0.
- R6: The status bit (offset 0xC, bit 0) sets in the cycle after any source pulses while its interrupt-mask bit is 1. A pulse whose mask bit is 0 leaves it unchanged. `irq_o` always equals this bit.
- R7: Any write to offset 0xC clears the status bit, whatever the data. If a qualifying pulse arrives in the same cycle as that write, the bit stays set.
- R8: `evt_o` is high for exactly the one cycle after a source pulses while its event-mask bit is 1. It does not depend on the interrupt mask.
- R9: The completion pulse is qualified by bit 7 of either mask and never sets an error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (0 when not selected) |
| err_pulse | input | 5 | Error condition pulses, bit order as in R2 |
| done_pulse | input | 1 | Instruction-completion pulse |
| irq_o | output | 1 | Level interrupt |
| evt_o | output | 1 | One-cycle event trigger |

## Verification
The bench focuses on same-cycle collisions: a clear against a set on a flag, and a status write against a qualifying pulse. A design where the clear wins would lose an error or an interrupt. It drives partial clear masks, so a design that wipes the whole flag register on any write would fail. It also checks routing: an error pulse with only the event mask set must not raise the interrupt, and completion must go through bit 7 alone. A design that mixes the masks or treats completion as an error would show a wrong flag, a wrong `irq_o` or an extra event. The bench also checks that `evt_o` drops after one cycle.

// File: rtl/cpx_notify_pkg.sv
package cpx_notify_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 4;
    localparam int NUM_ERR  = 5;
    localparam int SRC_W    = 8;
    localparam int DONE_BIT = 7;
    localparam int SEL_W    = ADDR_W - 2;

    localparam logic [SRC_W-1:0] EN_MASK = 8'h9F;

    typedef enum logic [SEL_W-1:0] {
        REG_ERR = 2'd0,
        REG_IEN = 2'd1,
        REG_EEN = 2'd2,
        REG_IST = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              err_clr;
        logic              ien_wr;
        logic              een_wr;
        logic              ist_clr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic [SRC_W-1:0] pack_src(
        input logic [NUM_ERR-1:0] err,
        input logic               done
    );
        logic [SRC_W-1:0] v;
        v                 = '0;
        v[NUM_ERR-1:0]    = err;
        v[DONE_BIT]       = done;
        return v;
    endfunction

endpackage

// File: rtl/cpx_reg_if.sv
module cpx_reg_if
    import cpx_notify_pkg::*;
(
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [NUM_ERR-1:0] flags,
    input  logic [SRC_W-1:0]   ien,
    input  logic [SRC_W-1:0]   een,
    input  logic               ist,
    output wr_req_t            req,
    output logic [DATA_W-1:0]  rdata
);

    reg_sel_e which;
    logic     do_wr;

    always_comb begin
        which = reg_sel_e'(bus_addr[ADDR_W-1:2]);
        do_wr = bus_sel && bus_wr;

        req         = '0;
        req.data    = bus_wdata;
        req.err_clr = do_wr && (which == REG_ERR);
        req.ien_wr  = do_wr && (which == REG_IEN);
        req.een_wr  = do_wr && (which == REG_EEN);
        req.ist_clr = do_wr && (which == REG_IST);
    end

    always_comb begin
        rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (which)
                REG_ERR: rdata[NUM_ERR-1:0] = flags;
                REG_IEN: rdata[SRC_W-1:0]   = ien;
                REG_EEN: rdata[SRC_W-1:0]   = een;
                REG_IST: rdata[0]           = ist;
                default: rdata              = '0;
            endcase
        end
    end

endmodule

// File: rtl/cpx_flag_bank.sv
module cpx_flag_bank
    import cpx_notify_pkg::*;
#(
    parameter int N = NUM_ERR
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic         clr_en,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flags
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[i] <= 1'b0;
            end else if (set_i[i]) begin
                flags[i] <= 1'b1;
            end else if (clr_en && clr_mask[i]) begin
                flags[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cpx_notify_gate.sv
module cpx_notify_gate
    import cpx_notify_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] src,
    input  wr_req_t          req,
    output logic [SRC_W-1:0] ien,
    output logic [SRC_W-1:0] een,
    output logic             ist,
    output logic             evt
);

    logic irq_hit;
    logic evt_hit;

    assign irq_hit = |(src & ien);
    assign evt_hit = |(src & een);

    always_ff @(posedge clk) begin
        if (rst) begin
            ien <= '0;
            een <= '0;
        end else begin
            if (req.ien_wr) ien <= req.data[SRC_W-1:0] & EN_MASK;
            if (req.een_wr) een <= req.data[SRC_W-1:0] & EN_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ist <= 1'b0;
        end else if (irq_hit) begin
            ist <= 1'b1;
        end else if (req.ist_clr) begin
            ist <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) evt <= 1'b0;
        else     evt <= evt_hit;
    end

endmodule

// File: rtl/cpx_notify_ctrl.sv
module cpx_notify_ctrl
    import cpx_notify_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_ERR-1:0] err_pulse,
    input  logic               done_pulse,
    output logic               irq_o,
    output logic               evt_o
);

    wr_req_t            req;
    logic [NUM_ERR-1:0] flags_q;
    logic [SRC_W-1:0]   ien_q;
    logic [SRC_W-1:0]   een_q;
    logic               ist_q;
    logic [SRC_W-1:0]   src;

    assign src = pack_src(err_pulse, done_pulse);

    cpx_reg_if u_regif (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .flags     (flags_q),
        .ien       (ien_q),
        .een       (een_q),
        .ist       (ist_q),
        .req       (req),
        .rdata     (bus_rdata)
    );

    cpx_flag_bank #(.N(NUM_ERR)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_i    (err_pulse),
        .clr_en   (req.err_clr),
        .clr_mask (req.data[NUM_ERR-1:0]),
        .flags    (flags_q)
    );

    cpx_notify_gate u_gate (
        .clk (clk),
        .rst (rst),
        .src (src),
        .req (req),
        .ien (ien_q),
        .een (een_q),
        .ist (ist_q),
        .evt (evt_o)
    );

    assign irq_o = ist_q;

endmodule

// File: rtl/cpx_notify_chk.sv
module cpx_notify_chk
    import cpx_notify_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [NUM_ERR-1:0] err_pulse,
    input logic               done_pulse,
    input logic [NUM_ERR-1:0] flags,
    input logic [SRC_W-1:0]   ien,
    input logic [SRC_W-1:0]   een,
    input logic               irq_o,
    input logic               evt_o
);

    logic wr_err;
    logic wr_ist;
    logic [SRC_W-1:0] srcv;

    assign wr_err = bus_sel && bus_wr && (bus_addr[ADDR_W-1:2] == REG_ERR);
    assign wr_ist = bus_sel && bus_wr && (bus_addr[ADDR_W-1:2] == REG_IST);
    assign srcv   = pack_src(err_pulse, done_pulse);

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !wr_err |=> ((flags & $past(flags)) == $past(flags))); // R2

    AST_FLAG_W1C: assert property (@(posedge clk) disable iff (rst)
        (wr_err && (err_pulse == '0)) |=> (flags == ($past(flags) & ~$past(bus_wdata[NUM_ERR-1:0])))); // R3

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (err_pulse != '0) |=> ((flags & $past(err_pulse)) == $past(err_pulse))); // R4

    AST_IRQ_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        ((srcv & ien) != '0) |=> irq_o); // R6

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !wr_ist) |=> irq_o); // R7

    AST_EVT_FIRE: assert property (@(posedge clk) disable iff (rst)
        ((srcv & een) != '0) |=> evt_o); // R8

    AST_EVT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ((srcv & een) == '0) |=> !evt_o); // R8

endmodule

bind cpx_notify_ctrl cpx_notify_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .err_pulse  (err_pulse),
    .done_pulse (done_pulse),
    .flags      (flags_q),
    .ien        (ien_q),
    .een        (een_q),
    .irq_o      (irq_o),
    .evt_o      (evt_o)
);

// File: tb/cpx_notify_ctrl_test.sv
module cpx_notify_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  err_pulse = '0;
    logic        done_pulse = 1'b0;
    logic        irq_o;
    logic        evt_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cpx_notify_ctrl uut (
        .clk        (clk),
        .rst        (rst),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .err_pulse  (err_pulse),
        .done_pulse (done_pulse),
        .irq_o      (irq_o),
        .evt_o      (evt_o)
    );

    typedef struct packed {
        logic [4:0] pulse;
        logic       done;
        logic [7:0] ie;
        logic [7:0] ee;
        logic [4:0] fl;
        logic       irq;
        logic       evt;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [0:NV-1] = '{
        '{5'h01, 1'b0, 8'h01, 8'h00, 5'h01, 1'b1, 1'b0},
        '{5'h02, 1'b0, 8'h01, 8'h02, 5'h02, 1'b0, 1'b1},
        '{5'h10, 1'b0, 8'h10, 8'h10, 5'h10, 1'b1, 1'b1},
        '{5'h00, 1'b1, 8'h80, 8'h00, 5'h00, 1'b1, 1'b0},
        '{5'h00, 1'b1, 8'h1F, 8'h80, 5'h00, 1'b0, 1'b1},
        '{5'h0C, 1'b0, 8'h04, 8'h08, 5'h0C, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one bus write, optionally with source pulses in the same cycle
    task automatic wr(input logic [3:0] a, input logic [31:0] d,
                      input logic [4:0] p, input logic dn);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        err_pulse = p; done_pulse = dn;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; err_pulse = '0; done_pulse = 1'b0;
    endtask

    task automatic pulse(input logic [4:0] p, input logic dn);
        @(negedge clk);
        err_pulse = p; done_pulse = dn;
        @(negedge clk);
        err_pulse = '0; done_pulse = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin
        repeat (25000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(4'h0, d); chk("R1 err", d, 0);
        rd(4'h4, d); chk("R1 ien", d, 0);
        rd(4'h8, d); chk("R1 een", d, 0);
        rd(4'hC, d); chk("R1 ist", d, 0);
        chk("R1 irq", {31'b0, irq_o}, 0);
        chk("R1 evt", {31'b0, evt_o}, 0);

        // table of routing vectors (R2 R6 R8 R9)
        for (int i = 0; i < NV; i++) begin
            wr(4'h0, 32'h1F, 5'h0, 1'b0);
            wr(4'hC, 32'h0, 5'h0, 1'b0);
            wr(4'h4, {24'h0, VEC[i].ie}, 5'h0, 1'b0);
            wr(4'h8, {24'h0, VEC[i].ee}, 5'h0, 1'b0);
            pulse(VEC[i].pulse, VEC[i].done);
            chk($sformatf("R8 vec%0d evt", i), {31'b0, evt_o}, {31'b0, VEC[i].evt});
            chk($sformatf("R6 vec%0d irq", i), {31'b0, irq_o}, {31'b0, VEC[i].irq});
            rd(4'h0, d);
            chk($sformatf("R2 R9 vec%0d flags", i), d, {27'b0, VEC[i].fl});
            rd(4'hC, d);
            chk($sformatf("R6 vec%0d ist", i), d, {31'b0, VEC[i].irq});
            @(negedge clk);
            chk($sformatf("R8 vec%0d evt drop", i), {31'b0, evt_o}, 0);
        end

        // R2 sticky across idle cycles
        wr(4'h0, 32'h1F, 5'h0, 1'b0);
        pulse(5'h1F, 1'b0);
        repeat (5) @(negedge clk);
        rd(4'h0, d); chk("R2 sticky", d, 32'h1F);

        // R3 partial write-one-to-clear
        wr(4'h0, 32'hFFFF_FFE5, 5'h0, 1'b0);
        rd(4'h0, d); chk("R3 w1c", d, 32'h1A);

        // R4 set beats clear on the same flag
        wr(4'h0, 32'h1F, 5'h08, 1'b0);
        rd(4'h0, d); chk("R4 set wins", d, 32'h08);

        // R5 reserved enable bits
        wr(4'h4, 32'hFFFF_FFFF, 5'h0, 1'b0);
        rd(4'h4, d); chk("R5 ien mask", d, 32'h9F);
        wr(4'h8, 32'hFFFF_FF60, 5'h0, 1'b0);
        rd(4'h8, d); chk("R5 een mask", d, 32'h0);

        // R7 clear by any data, and set beats clear
        wr(4'hC, 32'h0, 5'h0, 1'b0);
        pulse(5'h02, 1'b0);
        chk("R7 irq set", {31'b0, irq_o}, 1);
        wr(4'hC, 32'hDEAD_BEEE, 5'h0, 1'b0);
        chk("R7 cleared", {31'b0, irq_o}, 0);
        pulse(5'h0, 1'b1);
        wr(4'hC, 32'h1, 5'h01, 1'b0);
        chk("R7 set wins", {31'b0, irq_o}, 1);
        rd(4'hC, d); chk("R7 ist read", d, 1);

        // R6 disabled source leaves status alone
        wr(4'h4, 32'h01, 5'h0, 1'b0);
        wr(4'hC, 32'h0, 5'h0, 1'b0);
        pulse(5'h1E, 1'b1);
        chk("R6 masked", {31'b0, irq_o}, 0);

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(4'h0, d); chk("R1 flags after reset", d, 0);
        rd(4'h4, d); chk("R1 ien after reset", d, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule